// File: doc/BRIEF.md
# Push-Pull Ramp PWM Controller with Enforced Deadtime

This block generates fixed-frequency pulse-width-modulated drive for two output stages. A free-running up-counter serves as a digital sawtooth. Each count is compared with one threshold. That threshold is the largest of four values: a built-in deadtime floor, a programmable deadtime word, and two error words. The outputs are enabled only while the ramp lies above the threshold. A larger control word therefore gives a linearly narrower pulse, and the error input that asks for less on-time takes control.

At the start of every ramp the block forces a blank cycle. A steering flip-flop, clocked at the ramp wrap, sends successive pulses to output A and output B in turn, so each output runs at half the ramp rate. When the mode input selects single-ended operation, steering is frozen and both outputs carry the same pulse at the full ramp rate, so they can be wired in parallel.

The period, deadtime, error and mode inputs are sampled only at reset and at each ramp wrap, so a pulse is never cut or stretched partway through a ramp. The outputs are registered.

Top module: `pp_pwm_ctrl`

## Requirements
- R1: The ramp counts 0, 1, …, P and then returns to 0, so one ramp lasts P+1 clock cycles, where P is the latched period word. In single-ended mode, consecutive pulses therefore start P+1 cycles apart.
- R2: An output is high in the cycle after a ramp count C only if C > T. T is the largest of floor(P/25), the deadtime word and both error words. Each active ramp therefore carries a pulse of exactly P−T cycles when T < P.
- R3: In the cycle after the ramp count is 0, both outputs are low.
- R4: The two error words combine by maximum, so the larger one alone sets the pulse width.
- R5: With mode_single_i = 0 (push-pull), the first active ramp drives only out_a_o, the next only out_b_o, and so on alternately. The two outputs are never high together.
- R6: With mode_single_i = 1 (single-ended), out_a_o and out_b_o are identical in every cycle and pulse in every active ramp.
- R7: With a deadtime word of 0 and error words of 0, the pulse still starts only after count floor(P/25).
- R8: The period, deadtime, error and mode inputs are latched at reset and at each ramp wrap. A change made partway through a ramp first takes effect in the following ramp.
- R9: A synchronous active-high reset sets the ramp count to 0. Both outputs stay low through reset and through the whole first ramp after it.
- R10: When T ≥ P, both outputs stay low for the whole ramp (zero width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CW | Ramp top count P (ramp lasts P+1 cycles) |
| dead_i | input | CW | Programmable deadtime threshold |
| err_a_i | input | CW | First error / feedback word |
| err_b_i | input | CW | Second error / feedback word |
| mode_single_i | input | 1 | 1 = single-ended (both outputs together), 0 = push-pull |
| out_a_o | output | 1 | Output drive A (registered) |
| out_b_o | output | 1 | Output drive B (registered) |

## Verification
Some properties are checked on every cycle by assertions. The ramp count never exceeds the latched period. A high output always follows a count above the threshold. The cycle after ramp start is blank. Nothing is driven before the first wrap. Push-pull never drives both outputs at once, and steering toggles at each active push-pull wrap. Other properties can only be shown by the bench's scenarios, which compare every output cycle with a closed-form expectation. These are the exact pulse width per ramp, the spacing of pulses, the max-wins choice between the error words, the deadtime floor, the zero-width limit, and the deferral of mid-ramp changes to the next ramp.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  // Larger of two unsigned values.
  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Built-in deadtime floor: about 4 percent of the ramp.
  function automatic int unsigned dead_floor(input int unsigned top);
    return top / 25;
  endfunction

  // Effective threshold from the four candidates.
  function automatic int unsigned eff_threshold(input int unsigned top, input int unsigned dead,
                                                input int unsigned ea, input int unsigned eb);
    return max_u(max_u(dead_floor(top), dead), max_u(ea, eb));
  endfunction
endpackage

// File: rtl/pp_ramp.sv
module pp_ramp #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] dead_i,
  input  logic [CW-1:0] err_a_i,
  input  logic [CW-1:0] err_b_i,
  input  logic          mode_single_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] dead_o,
  output logic [CW-1:0] ea_o,
  output logic [CW-1:0] eb_o,
  output logic          md_o,
  output logic          wrap_o,
  output logic          start_o,
  output logic          armed_o
);
  logic [CW-1:0] cnt_q, per_q, dead_q, ea_q, eb_q;
  logic          md_q, armed_q;
  logic          wrap;

  assign wrap = (cnt_q == per_q);

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      per_q  <= period_i;
      dead_q <= dead_i;
      ea_q   <= err_a_i;
      eb_q   <= err_b_i;
      md_q   <= mode_single_i;
    end
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign per_o   = per_q;
  assign dead_o  = dead_q;
  assign ea_o    = ea_q;
  assign eb_o    = eb_q;
  assign md_o    = md_q;
  assign wrap_o  = wrap;
  assign start_o = (cnt_q == '0);
  assign armed_o = armed_q;

  assert_ramp_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= per_q);
  assert_restart_R1: assert property (@(posedge clk) disable iff (rst)
    $past(wrap) |-> (cnt_q == '0));
endmodule

// File: rtl/pp_thresh.sv
module pp_thresh #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] dead_i,
  input  logic [CW-1:0] ea_i,
  input  logic [CW-1:0] eb_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] thr_o,
  output logic [CW-1:0] fb_o,
  output logic          above_o
);
  import pp_pwm_pkg::*;

  assign fb_o    = CW'(max_u(32'(ea_i), 32'(eb_i)));
  assign thr_o   = CW'(eff_threshold(32'(per_i), 32'(dead_i), 32'(ea_i), 32'(eb_i)));
  assign above_o = (cnt_i > thr_o);

  // R4 / R7: threshold never below either error word or the floor
  always_comb begin
    assert_thr_floor_R7: assert (32'(thr_o) >= dead_floor(32'(per_i)));
    assert_thr_max_R4: assert ((thr_o >= ea_i) && (thr_o >= eb_i));
  end
endmodule

// File: rtl/pp_steer.sv
module pp_steer (
  input  logic clk,
  input  logic rst,
  input  logic wrap_i,
  input  logic armed_i,
  input  logic md_i,
  input  logic above_i,
  input  logic start_i,
  output logic out_a_o,
  output logic out_b_o
);
  logic steer_q;     // 0: pulse goes to A, 1: to B
  logic pulse_en;    // modulated pulse before steering

  assign pulse_en = above_i && armed_i && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      steer_q <= 1'b0;
      out_a_o <= 1'b0;
      out_b_o <= 1'b0;
    end else begin
      if (wrap_i && armed_i && !md_i) steer_q <= !steer_q;
      out_a_o <= pulse_en && (md_i || !steer_q);
      out_b_o <= pulse_en && (md_i ||  steer_q);
    end
  end

  assert_pp_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    (out_a_o && out_b_o) |-> $past(md_i));
  assert_steer_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    $past(wrap_i && armed_i && !md_i) |-> (steer_q != $past(steer_q)));
  assert_single_same_R6: assert property (@(posedge clk) disable iff (rst)
    $past(md_i) |-> (out_a_o == out_b_o));
endmodule

// File: rtl/pp_pwm_ctrl.sv
module pp_pwm_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] dead_i,
  input  logic [CW-1:0] err_a_i,
  input  logic [CW-1:0] err_b_i,
  input  logic          mode_single_i,
  output logic          out_a_o,
  output logic          out_b_o
);
  logic [CW-1:0] cnt, per_l, dead_l, ea_l, eb_l, thr, fb;
  logic          md_l, wrap, ramp_start, armed, above;

  pp_ramp #(.CW(CW)) u_ramp (
    .clk(clk), .rst(rst),
    .period_i(period_i), .dead_i(dead_i), .err_a_i(err_a_i), .err_b_i(err_b_i),
    .mode_single_i(mode_single_i),
    .cnt_o(cnt), .per_o(per_l), .dead_o(dead_l), .ea_o(ea_l), .eb_o(eb_l),
    .md_o(md_l), .wrap_o(wrap), .start_o(ramp_start), .armed_o(armed)
  );

  pp_thresh #(.CW(CW)) u_thresh (
    .per_i(per_l), .dead_i(dead_l), .ea_i(ea_l), .eb_i(eb_l), .cnt_i(cnt),
    .thr_o(thr), .fb_o(fb), .above_o(above)
  );

  pp_steer u_steer (
    .clk(clk), .rst(rst), .wrap_i(wrap), .armed_i(armed), .md_i(md_l),
    .above_i(above), .start_i(ramp_start),
    .out_a_o(out_a_o), .out_b_o(out_b_o)
  );

  assert_width_R2: assert property (@(posedge clk) disable iff (rst)
    (out_a_o || out_b_o) |-> ($past(cnt) > $past(thr)));
  assert_fb_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (out_a_o || out_b_o) |-> ($past(cnt) > $past(fb)));
  assert_blank_start_R3: assert property (@(posedge clk) disable iff (rst)
    $past(ramp_start) |-> (!out_a_o && !out_b_o));
  assert_idle_first_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(armed) |-> (!out_a_o && !out_b_o));
  assert_zero_width_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(thr) >= $past(per_l)) |-> (!out_a_o && !out_b_o));
endmodule

// File: tb/pp_pwm_ctrl_test.sv
module pp_pwm_ctrl_test;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] period_i = '0, dead_i = '0, err_a_i = '0, err_b_i = '0;
  logic          mode_single_i = 1'b0;
  logic          out_a_o, out_b_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  pp_pwm_ctrl #(.CW(CW)) uut (
    .clk(clk), .rst(rst), .period_i(period_i), .dead_i(dead_i),
    .err_a_i(err_a_i), .err_b_i(err_b_i), .mode_single_i(mode_single_i),
    .out_a_o(out_a_o), .out_b_o(out_b_o)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Inputs constant from reset, optionally changed (d2/ea2/eb2) at step chg_t.
  task automatic run(input int p, input int d, input int ea, input int eb, input bit single,
                     input int nramps, input string tag,
                     input int chg_t, input int d2, input int ea2, input int eb2);
    int len, chg_r, width, prev_start, cur_start;
    len = p + 1;
    chg_r = (chg_t >= 0) ? chg_t / len : nramps + 1;
    @(negedge clk);
    rst = 1'b1;
    period_i = CW'(p); dead_i = CW'(d); err_a_i = CW'(ea); err_b_i = CW'(eb);
    mode_single_i = single;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R9", "out_a in reset", int'(out_a_o), 0);
    chk("R9", "out_b in reset", int'(out_b_o), 0);
    rst = 1'b0;
    width = 0; prev_start = -1; cur_start = -1;
    for (int t = 0; t < nramps * len; t++) begin
      int c, r, thr, ea_x, eb_x, d_x;
      bit ea_sel, eb_sel, act;
      string tg;
      if (t == chg_t) begin
        dead_i = CW'(d2); err_a_i = CW'(ea2); err_b_i = CW'(eb2);
      end
      @(posedge clk);
      @(negedge clk);
      c = t % len;
      r = t / len;
      d_x  = (r > chg_r) ? d2  : d;
      ea_x = (r > chg_r) ? ea2 : ea;
      eb_x = (r > chg_r) ? eb2 : eb;
      thr = imax(imax(p / 25, d_x), imax(ea_x, eb_x));
      act = (r >= 1) && (c > thr);
      ea_sel = act && (single || (r % 2 == 1));
      eb_sel = act && (single || (r % 2 == 0));
      if (r == 0) tg = "R9";
      else if (c == 0) tg = "R3";
      else tg = tag;
      chk(tg, $sformatf("out_a t=%0d", t), int'(out_a_o), int'(ea_sel));
      chk(tg, $sformatf("out_b t=%0d", t), int'(out_b_o), int'(eb_sel));
      if (out_a_o || out_b_o) begin
        width++;
        if (cur_start < 0) cur_start = t;
      end
      if (c == p) begin
        if (r >= 1) chk("R2", $sformatf("width ramp %0d", r), width, imax(0, p - thr));
        if (single && cur_start >= 0) begin
          if (prev_start >= 0 && (r <= chg_r || r > chg_r + 1))
            chk("R1", "pulse spacing", cur_start - prev_start, len);
          prev_start = cur_start;
        end
        width = 0; cur_start = -1;
      end
    end
  endtask

  initial begin
    int plist[6] = '{0, 1, 24, 49, 100, 255};
    int dlist[3] = '{0, 3, 30};
    // reset state (R9)
    @(negedge clk);
    chk("R9", "out_a after reset", int'(out_a_o), 0);
    chk("R9", "out_b after reset", int'(out_b_o), 0);
    // sweep over period, deadtime and mode
    foreach (plist[i]) foreach (dlist[j]) for (int m = 0; m < 2; m++)
      run(plist[i], dlist[j], 0, 0, m[0], 4, (m == 1) ? "R6" : "R5", -1, 0, 0, 0);
    // floor only (R7)
    run(99, 0, 0, 0, 1'b1, 3, "R7", -1, 0, 0, 0);
    run(200, 0, 0, 0, 1'b0, 3, "R7", -1, 0, 0, 0);
    // error words, max wins (R4)
    run(99, 5, 10, 40, 1'b0, 4, "R4", -1, 0, 0, 0);
    run(99, 5, 60, 20, 1'b1, 3, "R4", -1, 0, 0, 0);
    run(120, 70, 30, 90, 1'b0, 4, "R4", -1, 0, 0, 0);
    // zero width (R10)
    run(50, 0, 50, 0, 1'b0, 3, "R10", -1, 0, 0, 0);
    run(50, 0, 0, 200, 1'b1, 3, "R10", -1, 0, 0, 0);
    run(50, 60, 0, 0, 1'b1, 3, "R10", -1, 0, 0, 0);
    // mid-ramp changes deferred (R8)
    run(99, 0, 10, 0, 1'b1, 4, "R8", 150, 0, 200, 0);
    run(99, 50, 0, 0, 1'b0, 5, "R8", 130, 0, 0, 5);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule